// File: doc/BRIEF.md
# I2C Target Interface with Service-Gated Clock Stretching

This block is the target side of an I2C bus. It runs on the system clock and oversamples the open-drain SCL and SDA lines through synchronisers. It detects START and STOP conditions and compares the first byte after a START with a programmable 7-bit own address. It moves data between the bus and a transmit holding register and a receive holding register. The bus outputs are pull-low enables, one for each line.

The block drives SCL low at three points: after it acknowledges its own address, after it acknowledges each received byte, and after the master acknowledges each transmitted byte. It keeps SCL low until local control logic clears the status flag for that point. For a read, software loads the next byte and then clears the flag. For a write, software reads the received byte and then clears the flag. Because of this stall, transmit underrun and receive overwrite cannot happen.

General call, 10-bit addressing and the master role are not part of this block.

Top module: `i2c_sl_stall`

## Requirements
- R1: After reset, `scl_oe`, `sda_oe`, `addr_hit`, `rx_ready`, `tx_empty` and `dir_rd` are all low.
- R2: The first 8 bits after a START are taken MSB first as a 7-bit address followed by a direction bit (1 = master reads). When the address equals `own_addr`, the block sets `addr_hit` and copies the direction bit to `dir_rd`. It also drives SDA low during the 9th SCL clock (ACK).
- R3: When the address does not match, the block drives neither line and sets no flag until the next START.
- R4: After the ACK clock that follows an address match, SCL stays low for as long as `addr_hit` is set. Pulsing `addr_clr` releases it.
- R5: In a write transfer, each received byte appears MSB first on `rx_data` after its 8th clock, `rx_ready` is set, and SDA is driven low during the 9th clock.
- R6: After each received byte is acknowledged, SCL is held low until `rx_clr` clears `rx_ready`. While the hold lasts, `rx_data` keeps its value even when the master already has the next byte ready.
- R7: In a read transfer, the byte written by `tx_wr` before `addr_clr` is sent MSB first as the first data byte. This first byte does not depend on `tx_empty`.
- R8: `tx_empty` is set once the 8th bit of a transmitted byte has been clocked out. If the master ACKs (SDA low on the 9th clock), SCL is held low until `tx_wr` supplies the next byte, and that byte is sent next.
- R9: A master NACK (SDA high on the 9th clock) after a transmitted byte makes the block release SDA and SCL and ignore further clocks until the next START.
- R10: A STOP or a repeated START resets the bit count. After a STOP both lines are released. After a repeated START a new address byte is decoded as in R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | SCL level sensed on the bus |
| sda_i | input | 1 | SDA level sensed on the bus |
| scl_oe | output | 1 | Pulls SCL low when 1 (clock stretch) |
| sda_oe | output | 1 | Pulls SDA low when 1 |
| own_addr | input | 7 | Address this target answers to |
| tx_data | input | 8 | Byte to load into the transmit holding register |
| tx_wr | input | 1 | Load pulse for `tx_data`; clears `tx_empty` |
| rx_data | output | 8 | Last byte received |
| rx_clr | input | 1 | Clears `rx_ready` |
| addr_hit | output | 1 | Own address recognised |
| addr_clr | input | 1 | Clears `addr_hit` |
| rx_ready | output | 1 | A received byte waits in `rx_data` |
| tx_empty | output | 1 | The held transmit byte has been sent |
| dir_rd | output | 1 | Direction bit of the last matching address |

## Verification
The hardest state to reach is one where the master has its next byte ready while the target holds SCL and software has not yet serviced the flag. Only in that state can a missing stall overwrite `rx_data` or send a stale transmit byte. The bench's master model waits on the wired-AND SCL level, as a real master does when stretched. Each such transfer runs forked alongside a software thread that waits tens of cycles, checks that `scl_oe` is still high and that `rx_data` or `tx_empty` is unchanged, and only then services the flag. The master's byte must then complete with the new value.

// File: rtl/i2c_sl_pkg.sv
package i2c_sl_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ADDR,
      ST_AACK,
      ST_RX,
      ST_RACK,
      ST_TX,
      ST_TACK,
      ST_HOLD,
      ST_REL
   } sl_state_t;

   typedef enum logic [1:0] {
      HK_ADDR,
      HK_RX,
      HK_TX
   } hold_kind_t;

endpackage

// File: rtl/i2c_sl_sync.sv
module i2c_sl_sync #(
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("i2c_sl_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/i2c_sl_cond.sv
module i2c_sl_cond (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   logic scl_q;
   logic sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   assign scl_rise  =  scl_s & ~scl_q;
   assign scl_fall  = ~scl_s &  scl_q;
   // SDA moves while SCL stays high
   assign start_det =  scl_s &  scl_q &  sda_q & ~sda_s;
   assign stop_det  =  scl_s &  scl_q & ~sda_q &  sda_s;

endmodule

// File: rtl/i2c_sl_stall.sv
module i2c_sl_stall
   import i2c_sl_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              scl_oe,
   output logic              sda_oe,
   input  logic [DATA_W-2:0] own_addr,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              tx_wr,
   output logic [DATA_W-1:0] rx_data,
   input  logic              rx_clr,
   output logic              addr_hit,
   input  logic              addr_clr,
   output logic              rx_ready,
   output logic              tx_empty,
   output logic              dir_rd
);

   localparam int ADDR_W = DATA_W - 1;
   localparam int CNT_W  = $clog2(DATA_W + 1);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);
   localparam logic [CNT_W-1:0] FULL     = CNT_W'(DATA_W);

   if (DATA_W < 2) begin : g_bad_width
      $error("i2c_sl_stall: DATA_W must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("i2c_sl_stall: SYNC_STAGES must be at least 2");
   end

   logic scl_s, sda_s;
   logic scl_rise, scl_fall, start_det, stop_det;

   sl_state_t         state;
   hold_kind_t        hold_kind;
   logic [CNT_W-1:0]  cnt;
   logic [DATA_W-1:0] sh;
   logic [DATA_W-1:0] tx_reg;
   logic              matched;
   logic              nack_q;
   logic              hold_clear;
   logic              go_tx;

   i2c_sl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_scl (
      .clk(clk), .rst_n(rst_n), .d(scl_i), .q(scl_s)
   );
   i2c_sl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sda (
      .clk(clk), .rst_n(rst_n), .d(sda_i), .q(sda_s)
   );
   i2c_sl_cond u_cond (
      .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det)
   );

   always_comb begin
      unique case (hold_kind)
         HK_ADDR: hold_clear = ~addr_hit;
         HK_RX:   hold_clear = ~rx_ready;
         HK_TX:   hold_clear = ~tx_empty;
         default: hold_clear = 1'b1;
      endcase
   end

   assign go_tx = (hold_kind == HK_TX) || ((hold_kind == HK_ADDR) && dir_rd);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         hold_kind <= HK_ADDR;
         cnt       <= '0;
         sh        <= '0;
         tx_reg    <= '0;
         rx_data   <= '0;
         addr_hit  <= 1'b0;
         rx_ready  <= 1'b0;
         tx_empty  <= 1'b0;
         dir_rd    <= 1'b0;
         matched   <= 1'b0;
         nack_q    <= 1'b0;
         scl_oe    <= 1'b0;
         sda_oe    <= 1'b0;
      end else begin
         // software clears; bus-side sets below take precedence
         if (addr_clr) addr_hit <= 1'b0;
         if (rx_clr)   rx_ready <= 1'b0;
         if (tx_wr) begin
            tx_reg   <= tx_data;
            tx_empty <= 1'b0;
         end

         if (start_det) begin
            state   <= ST_ADDR;
            cnt     <= '0;
            matched <= 1'b0;
            scl_oe  <= 1'b0;
            sda_oe  <= 1'b0;
         end else if (stop_det) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            scl_oe <= 1'b0;
            sda_oe <= 1'b0;
         end else begin
            unique case (state)
               ST_ADDR: begin
                  if (scl_rise) begin
                     sh  <= {sh[DATA_W-2:0], sda_s};
                     cnt <= cnt + CNT_W'(1);
                     if (cnt == LAST_BIT && sh[ADDR_W-1:0] == own_addr) begin
                        matched  <= 1'b1;
                        addr_hit <= 1'b1;
                        dir_rd   <= sda_s;
                     end
                  end else if (scl_fall && cnt == FULL) begin
                     if (matched) begin
                        sda_oe <= 1'b1;
                        state  <= ST_AACK;
                     end else begin
                        state  <= ST_IDLE;
                     end
                  end
               end
               ST_AACK, ST_RACK: begin
                  if (scl_fall) begin
                     sda_oe    <= 1'b0;
                     scl_oe    <= 1'b1;
                     cnt       <= '0;
                     hold_kind <= (state == ST_AACK) ? HK_ADDR : HK_RX;
                     state     <= ST_HOLD;
                  end
               end
               ST_RX: begin
                  if (scl_rise) begin
                     sh  <= {sh[DATA_W-2:0], sda_s};
                     cnt <= cnt + CNT_W'(1);
                     if (cnt == LAST_BIT) begin
                        rx_data  <= {sh[DATA_W-2:0], sda_s};
                        rx_ready <= 1'b1;
                     end
                  end else if (scl_fall && cnt == FULL) begin
                     sda_oe <= 1'b1;
                     state  <= ST_RACK;
                  end
               end
               ST_TX: begin
                  if (scl_rise) begin
                     sh  <= {sh[DATA_W-2:0], 1'b1};
                     cnt <= cnt + CNT_W'(1);
                  end else if (scl_fall) begin
                     if (cnt == FULL) begin
                        sda_oe   <= 1'b0;
                        tx_empty <= 1'b1;
                        state    <= ST_TACK;
                     end else begin
                        sda_oe <= ~sh[DATA_W-1];
                     end
                  end
               end
               ST_TACK: begin
                  if (scl_rise) begin
                     nack_q <= sda_s;
                  end else if (scl_fall) begin
                     if (nack_q) begin
                        state <= ST_IDLE;
                     end else begin
                        scl_oe    <= 1'b1;
                        cnt       <= '0;
                        hold_kind <= HK_TX;
                        state     <= ST_HOLD;
                     end
                  end
               end
               ST_HOLD: begin
                  if (hold_clear) begin
                     state <= ST_REL;
                     if (go_tx) begin
                        sh     <= tx_reg;
                        sda_oe <= ~tx_reg[DATA_W-1];
                     end
                  end
               end
               ST_REL: begin
                  // SDA settled one cycle before SCL is let go
                  scl_oe <= 1'b0;
                  state  <= go_tx ? ST_TX : ST_RX;
               end
               default: begin
               end
            endcase
         end
      end
   end

endmodule

// File: rtl/i2c_sl_stall_chk.sv
module i2c_sl_stall_chk
   import i2c_sl_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input sl_state_t         state,
   input hold_kind_t        hold_kind,
   input logic              addr_hit,
   input logic              rx_ready,
   input logic              tx_empty,
   input logic              scl_oe,
   input logic              sda_oe,
   input logic              rx_clr,
   input logic [DATA_W-1:0] rx_data
);

   p_ack_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_AACK) |-> sda_oe);

   p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |-> (!scl_oe && !sda_oe));

   p_hold_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_HOLD && hold_kind == HK_ADDR && addr_hit) |=> scl_oe);

   p_hold_rx_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_HOLD && hold_kind == HK_RX && rx_ready) |=> scl_oe);

   p_rx_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_ready && !rx_clr) |=> $stable(rx_data));

   p_hold_tx_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_HOLD && hold_kind == HK_TX && tx_empty) |=> scl_oe);

   p_txe_sda_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_empty) |-> !sda_oe);

endmodule

bind i2c_sl_stall i2c_sl_stall_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/i2c_sl_stall_tb.sv
module i2c_sl_stall_tb;

   localparam int Q = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic m_scl = 1'b1;
   logic m_sda = 1'b1;
   logic scl_bus, sda_bus;
   logic scl_oe, sda_oe;
   logic [6:0] own_addr = 7'h3A;
   logic [7:0] tx_data = '0;
   logic tx_wr = 1'b0, rx_clr = 1'b0, addr_clr = 1'b0;
   logic [7:0] rx_data;
   logic addr_hit, rx_ready, tx_empty, dir_rd;

   assign scl_bus = m_scl & ~scl_oe;
   assign sda_bus = m_sda & ~sda_oe;

   i2c_sl_stall u_dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
      .scl_oe(scl_oe), .sda_oe(sda_oe), .own_addr(own_addr),
      .tx_data(tx_data), .tx_wr(tx_wr), .rx_data(rx_data), .rx_clr(rx_clr),
      .addr_hit(addr_hit), .addr_clr(addr_clr), .rx_ready(rx_ready),
      .tx_empty(tx_empty), .dir_rd(dir_rd)
   );

   int n_chk = 0;
   int n_fail = 0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wq(input int n = Q);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_scl_hi();
      while (!scl_bus) @(negedge clk);
   endtask

   task automatic m_bit(input logic b, output logic r);
      m_sda = b; wq();
      m_scl = 1'b1; wait_scl_hi(); wq();
      r = sda_bus; wq();
      m_scl = 1'b0; wq();
   endtask

   task automatic m_start();
      m_sda = 1'b1; wq();
      m_scl = 1'b1; wait_scl_hi(); wq();
      m_sda = 1'b0; wq();
      m_scl = 1'b0; wq();
   endtask

   task automatic m_stop();
      m_sda = 1'b0; wq();
      m_scl = 1'b1; wait_scl_hi(); wq();
      m_sda = 1'b1; wq();
   endtask

   task automatic m_write(input logic [7:0] d, output logic ack);
      logic r;
      for (int i = 7; i >= 0; i--) m_bit(d[i], r);
      m_bit(1'b1, ack);
   endtask

   task automatic m_read(output logic [7:0] d, input logic nack);
      logic r;
      for (int i = 7; i >= 0; i--) begin
         m_bit(1'b1, r);
         d[i] = r;
      end
      m_bit(nack, r);
   endtask

   task automatic sw_addr_clr();
      @(negedge clk) addr_clr = 1'b1;
      @(negedge clk) addr_clr = 1'b0;
   endtask

   task automatic sw_rx_clr();
      @(negedge clk) rx_clr = 1'b1;
      @(negedge clk) rx_clr = 1'b0;
   endtask

   task automatic sw_tx(input logic [7:0] d);
      @(negedge clk) begin tx_data = d; tx_wr = 1'b1; end
      @(negedge clk) tx_wr = 1'b0;
   endtask

   // {own address, address byte on the bus, expect ACK}
   localparam logic [15:0] VEC [7] = '{
      {7'h3A, 8'h74, 1'b1},
      {7'h3A, 8'h75, 1'b1},
      {7'h3A, 8'h76, 1'b0},
      {7'h7F, 8'hFE, 1'b1},
      {7'h7F, 8'h7E, 1'b0},
      {7'h51, 8'hA3, 1'b1},
      {7'h2C, 8'hD8, 1'b0}
   };

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      logic ack, ack2, r;
      logic [7:0] d, d2;

      wq(5);
      rst_n = 1'b1;
      wq(5);
      // R1: quiet after reset
      chk("R1 scl_oe", scl_oe, 0);
      chk("R1 sda_oe", sda_oe, 0);
      chk("R1 flags", {addr_hit, rx_ready, tx_empty, dir_rd}, 0);

      // Address table: R2 match, R3 mismatch, R4 hold
      for (int i = 0; i < 7; i++) begin
         logic [7:0] ab;
         logic       e;
         own_addr = VEC[i][15:9];
         ab       = VEC[i][8:1];
         e        = VEC[i][0];
         m_start();
         m_write(ab, ack);
         if (e) begin
            chk("R2 ack", ack, 0);
            chk("R2 addr_hit", addr_hit, 1);
            chk("R2 dir_rd", dir_rd, ab[0]);
            chk("R4 scl held", scl_oe, 1);
            if (ab[0]) sw_tx(8'hFF);
            sw_addr_clr();
         end else begin
            chk("R3 no ack", ack, 1);
            chk("R3 no flag", addr_hit, 0);
            chk("R3 lines free", {scl_oe, sda_oe}, 0);
         end
         m_stop();
         wq(5);
      end

      // Write transfer with receive stall
      own_addr = 7'h3A;
      m_start();
      m_write(8'h74, ack);
      wq(20);
      chk("R4 held while flag set", scl_oe, 1);
      sw_addr_clr();
      wq(5);
      chk("R4 flag cleared", addr_hit, 0);
      m_write(8'hA5, ack);
      chk("R5 data ack", ack, 0);
      chk("R5 rx_data", rx_data, 8'hA5);
      chk("R5 rx_ready", rx_ready, 1);
      chk("R6 scl held", scl_oe, 1);
      fork
         m_write(8'h5C, ack2);
         begin
            wq(60);
            chk("R6 no overwrite", rx_data, 8'hA5);
            chk("R6 still held", scl_oe, 1);
            sw_rx_clr();
         end
      join
      chk("R6 second ack", ack2, 0);
      chk("R6 second byte", rx_data, 8'h5C);
      sw_rx_clr();
      m_stop();
      wq(5);
      chk("R10 lines free after stop", {scl_oe, sda_oe}, 0);

      // Read transfer with transmit stall
      m_start();
      m_write(8'h75, ack);
      chk("R7 dir_rd", dir_rd, 1);
      sw_tx(8'hC3);
      sw_addr_clr();
      m_read(d, 1'b0);
      chk("R7 first byte", d, 8'hC3);
      chk("R8 tx_empty", tx_empty, 1);
      chk("R8 scl held", scl_oe, 1);
      fork
         m_read(d2, 1'b1);
         begin
            wq(60);
            chk("R8 still held", scl_oe, 1);
            chk("R8 still empty", tx_empty, 1);
            sw_tx(8'h96);
         end
      join
      chk("R8 second byte", d2, 8'h96);
      wq(3);
      chk("R9 lines free after nack", {scl_oe, sda_oe}, 0);
      m_bit(1'b1, r);
      chk("R9 no drive after nack", r, 1);
      m_stop();
      wq(5);

      // Repeated START mid-byte
      m_start();
      m_write(8'h74, ack);
      sw_addr_clr();
      m_bit(1'b0, r);
      m_start();
      m_write(8'h75, ack);
      chk("R10 ack after repeated start", ack, 0);
      chk("R10 dir_rd", dir_rd, 1);
      chk("R10 addr_hit", addr_hit, 1);
      sw_tx(8'hFF);
      sw_addr_clr();
      m_stop();
      wq(5);
      chk("R10 idle", {scl_oe, sda_oe}, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule